// File: doc/BRIEF.md
# Late-Write Synchronous Memory

This block is a clocked single-port memory. Its word is made of byte lanes, each nine bits wide, and the default has four lanes, so a word is 36 bits. Address and controls are taken on each rising clock edge, and the data for that access moves one cycle later. A read drives the stored word on `dout` during the following cycle, and `dq_oe` says when the data pins would be driven. A write takes its data from `wdata` on the edge after the one that accepted its address. Each lane has its own active-low write enable.

Write data arrives late, so the block holds the address and lane mask of an accepted write in a pending register. It commits the write on the next edge. A read that reaches the same address on that edge sees the new lanes through a bypass merge. Reads and writes can follow each other in any order on consecutive cycles, with no idle cycle between them. The separate `wdata`, `dout` and `dq_oe` signals stand in for a shared bidirectional data bus.

The port timing is fixed by the clock, with no valid/ready handshake. Every accepted access completes in exactly one cycle, so there is no back-pressure.

Top module: `lsram_top`

## Requirements
- R1: When `sleep` is low, `sel_n` is low and `wr_n` is high at a rising edge, the whole word at `addr` is read, whatever `bw_n` holds. The word appears on `dout` with `dq_oe` high during the next cycle, provided `oe_n` and `sleep` are low at that time.
- R2: When `sel_n` and `wr_n` are low at an edge and `sleep` is low, each lane i with `bw_n[i]` low is written. Lane i is bits 9i to 9i+8 of the word, so lane 0 is bits 0 to 8 and lane 3 is bits 27 to 35. The data is taken from `wdata` on the following edge, and lanes whose enable is high keep their contents.
- R3: A cycle with `sel_n` and `wr_n` low and all of `bw_n` high is an aborted write. No lane changes and `dq_oe` stays low in the next cycle.
- R4: With `sel_n` high at an edge, no access happens and `dq_oe` is low during the next cycle, whatever `wr_n` and `bw_n` hold.
- R5: With `sleep` high at an edge, no access starts, whatever the other controls hold. While `sleep` is high, `dq_oe` is low at once, without waiting for a clock. A write accepted on the previous edge still commits.
- R6: `oe_n` acts without a clock. While it is high, `dq_oe` is low even in the cycle after a read. It has no effect in cycles after writes, deselects or sleeps, when `dq_oe` is low anyway.
- R7: With all of `bw_n` low, all lanes of the word are written in one cycle.
- R8: A read on the edge that commits an earlier write to the same address returns the new data in the written lanes and the stored data in the other lanes.
- R9: Reads and writes are accepted on every cycle in any order (write after write, read after write, write after read), with no idle cycle needed.
- R10: A synchronous reset (`rst_n` low at an edge) clears only the pipeline state. After it, `dq_oe` is low, and a write whose data was due on the reset edge is dropped. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of pipeline control |
| sleep | input | 1 | Sleep: blocks access starts and forces pins off |
| sel_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write; high means read |
| bw_n | input | LANES (4) | Active-low per-lane write enables |
| addr | input | log2(DEPTH) (10) | Word address |
| wdata | input | LANES*LANE_W (36) | Write data, taken one edge after its address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dout | output | LANES*LANE_W (36) | Read data of the last read |
| dq_oe | output | 1 | High when the data pins would be driven |

## Verification
Assertions check on every cycle that deselect, aborted write and sleep leave the pins undriven in the next cycle. They also check that `oe_n` and `sleep` force `dq_oe` low without a clock, and that a read with the output enabled drives the pins. A lane written on a commit edge must hold the supplied data afterwards. Whether a read returns the correctly merged word can only be shown by the bench's scenarios. These include a read right after a write to the same address, partial-lane writes, aborted writes, reads with the enable low and a reset that drops a pending write, all compared against a bench model of the memory contents.

// File: rtl/lsram_pkg.sv
package lsram_pkg;
  // kind of access accepted on a clock edge
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/lsram_issue.sv
module lsram_issue
  import lsram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_go,
  output acc_e              acc_q,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  wr_mask
);
  acc_e             acc_d;
  logic [LANES-1:0] lane_sel;

  // decode the controls sampled on this edge
  always_comb begin
    lane_sel = ~bw_n;
    acc_d    = ACC_NONE;
    if (!sleep && !sel_n) begin
      if (wr_n)           acc_d = ACC_READ;
      else if (|lane_sel) acc_d = ACC_WRITE;
    end
  end

  assign rd_go = rst_n && (acc_d == ACC_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= ACC_NONE;
    else        acc_q <= acc_d;
  end

  // pending write: address and lanes wait for the late data
  always_ff @(posedge clk) begin
    if (acc_d == ACC_WRITE) begin
      wr_addr <= addr;
      wr_mask <= lane_sel;
    end
  end

  // R3
  abort_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !sel_n && !wr_n && (&bw_n)) |=> (acc_q != ACC_WRITE));

  // R5
  sleep_no_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (acc_q == ACC_NONE));
endmodule

// File: rtl/lsram_lane_merge.sv
module lsram_lane_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] new_word,
  input  logic [LANES-1:0]  take_new,
  output logic [WORD_W-1:0] merged
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = take_new[l] ? new_word[l*LANE_W +: LANE_W]
                                                    : old_word[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lsram_store.sv
module lsram_store #(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wmask,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rword
);
  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar l = 0; l < LANES; l++) begin : g_wlane
    always_ff @(posedge clk) begin
      if (we && wmask[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
  end

  assign rword = mem[raddr];

  // R2
  lane0_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wmask[0]) |=> (mem[$past(waddr)][LANE_W-1:0] == $past(wdata[LANE_W-1:0])));
endmodule

// File: rtl/lsram_top.sv
module lsram_top
  import lsram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              oe_n,
  output logic [WORD_W-1:0] dout,
  output logic              dq_oe
);
  logic              rd_go;
  acc_e              acc_q;
  logic [ADDR_W-1:0] wr_addr;
  logic [LANES-1:0]  wr_mask;
  logic              commit;
  logic              hit;
  logic [LANES-1:0]  byp_mask;
  logic [WORD_W-1:0] rword;
  logic [WORD_W-1:0] rd_merged;
  logic [WORD_W-1:0] rd_q;

  lsram_issue #(.LANES(LANES), .ADDR_W(ADDR_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .wr_n(wr_n),
    .bw_n(bw_n), .addr(addr), .rd_go(rd_go), .acc_q(acc_q),
    .wr_addr(wr_addr), .wr_mask(wr_mask)
  );

  // write issued last edge commits on this edge with the late data
  assign commit   = rst_n && (acc_q == ACC_WRITE);
  assign hit      = commit && rd_go && (addr == wr_addr);
  assign byp_mask = hit ? wr_mask : '0;

  lsram_store #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(commit), .waddr(wr_addr), .wmask(wr_mask),
    .wdata(wdata), .raddr(addr), .rword(rword)
  );

  lsram_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .old_word(rword), .new_word(wdata), .take_new(byp_mask), .merged(rd_merged)
  );

  always_ff @(posedge clk) begin
    if (rd_go) rd_q <= rd_merged;
  end

  assign dout  = rd_q;
  assign dq_oe = (acc_q == ACC_READ) && !oe_n && !sleep;

  // R4
  desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && !sleep) |=> !dq_oe);

  // R5
  sleep_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);

  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  // R1
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !sel_n && wr_n) |=> (dq_oe || oe_n || sleep));

  // R3
  abort_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !sel_n && !wr_n && (&bw_n)) |=> !dq_oe);
endmodule

// File: tb/tb_lsram_top.sv
`timescale 1ns/1ps
module tb_lsram_top;
  localparam int DEPTH = 1024;
  localparam int LANES = 4;
  localparam int LW    = 9;
  localparam int AW    = $clog2(DEPTH);
  localparam int WW    = LANES * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sleep = 1'b0, sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b0;
  logic [LANES-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] dout;
  logic dq_oe;

  always #2 clk = ~clk;

  lsram_top #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .wr_n(wr_n),
    .bw_n(bw_n), .addr(addr), .wdata(wdata), .oe_n(oe_n), .dout(dout), .dq_oe(dq_oe)
  );

  int vectors = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [WW-1:0]    mm [DEPTH];
  logic [LANES-1:0] kn [DEPTH];
  bit pv = 0; int pa = 0; logic [LANES-1:0] pm = '0;
  bit prv_rd = 0; logic [WW-1:0] ew = '0; logic [LANES-1:0] ek = '0;
  string prv_tag = "R10";
  bit rst_bit = 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // k: 0 read, 1 write, 2 deselect, 3 sleep; pay is data for the write pending from the last step
  task automatic step(input int k, input int a, input logic [LANES-1:0] bw,
                      input bit oe, input logic [WW-1:0] pay);
    bit exp_oe, hit;
    string t;
    @(negedge clk);
    rst_n = !rst_bit;
    sleep = (k == 3);
    sel_n = (k == 2) ? 1'b1 : (k == 3) ? 1'($urandom) : 1'b0;
    wr_n  = (k == 0) ? 1'b1 : (k == 1) ? 1'b0 : 1'($urandom);
    bw_n  = bw; addr = AW'(a); oe_n = oe; wdata = pay;
    #1;
    exp_oe = prv_rd && !oe && !sleep;
    t = (prv_rd && sleep) ? "R5" : (prv_rd && oe) ? "R6" : prv_tag;
    chk(dq_oe == exp_oe, t, 64'(dq_oe), 64'(exp_oe));
    if (exp_oe)
      for (int l = 0; l < LANES; l++)
        if (ek[l]) chk(dout[l*LW +: LW] == ew[l*LW +: LW], prv_tag,
                       64'(dout[l*LW +: LW]), 64'(ew[l*LW +: LW]));
    @(posedge clk);
    if (rst_bit) begin
      pv = 0; prv_rd = 0; prv_tag = "R10";
    end else begin
      if (pv)
        for (int l = 0; l < LANES; l++)
          if (pm[l]) begin mm[pa][l*LW +: LW] = pay[l*LW +: LW]; kn[pa][l] = 1'b1; end
      hit = pv && (k == 0) && (a == pa);
      pv = 0; prv_rd = 0;
      case (k)
        0: begin prv_rd = 1; ew = mm[a]; ek = kn[a]; prv_tag = hit ? "R8" : "R1"; end
        1: if (bw != '1) begin
             pv = 1; pa = a; pm = ~bw; prv_tag = (bw == '0) ? "R7" : "R2";
           end else prv_tag = "R3";
        2: prv_tag = "R4";
        default: prv_tag = "R5";
      endcase
    end
  endtask

  function automatic logic [WW-1:0] rw();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(4 * 150000);
    errors++; vectors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < DEPTH; i++) kn[i] = '0;
    // R10 reset state: no drive
    step(2, 0, '1, 0, rw());
    step(2, 0, '1, 0, rw());
    rst_bit = 0;
    step(2, 0, '1, 0, rw());
    // R7 all lanes, then R8/R9 read right after write to same address
    step(1, 3, 4'h0, 0, rw());
    step(0, 3, 4'h5, 0, 36'h123456789);
    // R9 write right after read, lane 1 only (R2)
    step(1, 3, 4'b1101, 0, rw());
    step(0, 3, 4'h0, 0, 36'hABCDEF012);   // R8 merged partial lanes
    step(2, 0, '1, 0, rw());
    step(0, 3, '1, 0, rw());
    // R3 aborted write then read unchanged
    step(1, 3, 4'hF, 0, rw());
    step(0, 3, '1, 0, rw());
    // R6 read with output disabled
    step(0, 3, '1, 1, rw());
    step(0, 3, '1, 0, rw());
    // R5 sleep right after a read
    step(3, 3, 4'h0, 0, rw());
    step(2, 0, '1, 0, rw());
    // R10 reset drops a pending write
    step(1, 3, 4'h0, 0, rw());
    rst_bit = 1;
    step(2, 0, '1, 0, rw());
    rst_bit = 0;
    step(0, 3, '1, 0, rw());
    step(2, 0, '1, 0, rw());
    // lane boundary address
    step(1, DEPTH - 1, 4'h0, 0, rw());
    step(0, DEPTH - 1, '1, 0, rw());
    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int r, k, a;
      logic [LANES-1:0] bw;
      r = $urandom % 100;
      k = (r < 35) ? 0 : (r < 72) ? 1 : (r < 86) ? 2 : 3;
      a = ($urandom % 8 == 0) ? (DEPTH - 1 - int'($urandom % 2)) : int'($urandom % 16);
      bw = LANES'($urandom);
      if ($urandom % 8 == 0) bw = '0;
      if ($urandom % 10 == 0) bw = '1;
      step(k, a, bw, ($urandom % 5 == 0), rw());
    end
    step(2, 0, '1, 0, rw());
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule